// File: doc/BRIEF.md
# Dirty-Band Display Update Scanner

The scanner walks a per-page dirty bitmap from the top of the frame to the bottom. It turns the dirty bitmap into a short list of screen update rectangles. Each bitmap page stands for a band of four scan lines. The scanner reads one band per cycle through a read port. The bitmap itself lives outside the block, and its read is combinational. A run of dirty bands becomes one rectangle. The scanner closes that rectangle when it meets a clean band or reaches the bottom of the frame. Each rectangle goes out as a full-width update command that carries a first line and a line count. Commands leave over a valid/ready handshake.

When the walk ends, the scanner issues a single range-clear command. The command covers every page from the lowest dirty page it saw to the highest. It also names the planes to clear. In palette mode only the index plane decides whether a band is dirty. In deep-colour mode a band is dirty when any of the three planes marks it: index, direct colour or control. In that mode the clear covers all three planes. An invalidate pulse arms a one-shot flag, and the next scan then treats every band as dirty. The frame height is a runtime value. It is sampled at start and need not be a multiple of four.

Top module: `dirty_band_scanner`

## Requirements
- R1: After reset, `upd_valid`, `clr_valid`, `done` and `busy` are all low.
- R2: Band p covers lines 4p to 4p+3, and `rd_page` presents p while band p is examined. A rectangle's `upd_line` is always 4 times the page of its first dirty band, so its two low bits are zero.
- R3: Consecutive dirty bands merge into one rectangle. A clean band that follows dirty bands emits that rectangle, with `upd_count` equal to the clean band's first line minus `upd_line`. No command has a zero count.
- R4: A rectangle still open when the walk reaches the frame height is emitted at the end. Its count is clipped so that `upd_line + upd_count` equals the sampled height, including heights that are not a multiple of four.
- R5: With `deep_mode` low, only `rd_dirty[0]` (index plane) marks a band dirty. Bits 1 and 2 are ignored and are not cleared.
- R6: With `deep_mode` high, a band is dirty if any of `rd_dirty[0]` (index), `rd_dirty[1]` (direct colour) or `rd_dirty[2]` (control) is set.
- R7: After the walk there is exactly one one-cycle `clr_valid` pulse. It carries `clr_first` = lowest dirty page and `clr_last` = highest dirty page, with `clr_planes` = 3'b001 in palette mode and 3'b111 in deep mode. If no band was dirty, no pulse occurs.
- R8: An `invalidate` pulse seen while idle makes the next scan treat every band as dirty. That scan emits one rectangle from line 0 to the height and a clear over pages 0 to ceil(height/4)-1. The flag is consumed by that scan.
- R9: While `upd_valid` is high and `upd_ready` is low, `upd_valid`, `upd_line` and `upd_count` hold their values. A command is accepted on each edge where both are high.
- R10: `done` pulses for one cycle after the clear, only once every command has been accepted, and `busy` then falls. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan when idle |
| deep_mode | input | 1 | 1: three-plane dirty test; 0: index plane only |
| invalidate | input | 1 | Arm a whole-screen redraw for the next scan |
| frame_height | input | LINE_W (10) | Visible lines, sampled at start |
| rd_page | output | PAGE_W (8) | Page whose dirty bits are read this cycle |
| rd_dirty | input | 3 | Dirty bits of `rd_page`: [0] index, [1] direct colour, [2] control |
| upd_valid | output | 1 | Update command valid |
| upd_ready | input | 1 | Consumer accepts the command |
| upd_line | output | LINE_W (10) | First line of the rectangle (x spans the full width) |
| upd_count | output | LINE_W (10) | Number of lines in the rectangle |
| clr_valid | output | 1 | One-cycle range-clear command |
| clr_first | output | PAGE_W (8) | First page to clear |
| clr_last | output | PAGE_W (8) | Last page to clear, inclusive |
| clr_planes | output | 3 | Planes to clear |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The assertions rely on three properties of the inputs:
- `rd_dirty` reflects `rd_page` in the same cycle.
- `frame_height` is at most the configured maximum. Larger values are clipped anyway.
- The consumer may hold `upd_ready` low for any number of cycles but not forever.

The stimulus keeps to all three. The bench models the bitmap as an array indexed combinationally by `rd_page`. It draws heights between 1 and the maximum, and it drives `upd_ready` with a random duty between 30 and 100 percent so that every stall ends. It also applies each clear to its own bitmap. This lets a follow-up scan show which planes were left untouched.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int NUM_PLANES = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CLEAR,
        ST_DRAIN
    } scan_state_e;

    // Planes that take part in the dirty test and in the clear.
    function automatic logic [NUM_PLANES-1:0] plane_mask(input logic deep);
        return deep ? {NUM_PLANES{1'b1}} : NUM_PLANES'(1);
    endfunction

endpackage

// File: rtl/dbs_dirty_qual.sv
module dbs_dirty_qual
    import dbs_pkg::*;
(
    input  logic                  deep,
    input  logic                  force_all,
    input  logic [NUM_PLANES-1:0] bits,
    output logic                  dirty
);
    logic [NUM_PLANES-1:0] mask;
    logic [NUM_PLANES-1:0] eff;

    assign mask = plane_mask(deep);

    for (genvar i = 0; i < NUM_PLANES; i++) begin : g_plane
        assign eff[i] = bits[i] & mask[i];
    end

    assign dirty = force_all | (|eff);
endmodule

// File: rtl/dbs_extent.sv
module dbs_extent #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              hit,
    input  logic [PAGE_W-1:0] page,
    output logic              any,
    output logic [PAGE_W-1:0] lo,
    output logic [PAGE_W-1:0] hi
);
    // Pages arrive in ascending order, so the first hit is the minimum
    // and the latest hit is the maximum.
    always_ff @(posedge clk) begin
        if (rst || init) begin
            any <= 1'b0;
            lo  <= '0;
            hi  <= '0;
        end else if (hit) begin
            if (!any) lo <= page;
            hi  <= page;
            any <= 1'b1;
        end
    end

    AST_EXTENT_ORDER: assert property (@(posedge clk) disable iff (rst)
        any |-> (lo <= hi)); // R7
endmodule

// File: rtl/dbs_rect_out.sv
module dbs_rect_out #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] line_in,
    input  logic [LINE_W-1:0] count_in,
    input  logic              ready,
    output logic              valid,
    output logic [LINE_W-1:0] line_out,
    output logic [LINE_W-1:0] count_out,
    output logic              stall
);
    assign stall = valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid     <= 1'b0;
            line_out  <= '0;
            count_out <= '0;
        end else if (load) begin
            valid     <= 1'b1;
            line_out  <= line_in;
            count_out <= count_in;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(line_out) && $stable(count_out))); // R9
    AST_NO_LOAD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        stall |-> !load); // R9
endmodule

// File: rtl/dirty_band_scanner.sv
module dirty_band_scanner
    import dbs_pkg::*;
#(
    parameter  int MAX_LINES = 768,
    parameter  int BAND_LOG2 = 2,
    localparam int BAND_LINES = 1 << BAND_LOG2,
    localparam int NPAGES = (MAX_LINES + BAND_LINES - 1) / BAND_LINES,
    localparam int PAGE_W = $clog2(NPAGES + 1),
    localparam int LINE_W = $clog2(MAX_LINES + BAND_LINES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  deep_mode,
    input  logic                  invalidate,
    input  logic [LINE_W-1:0]     frame_height,
    output logic [PAGE_W-1:0]     rd_page,
    input  logic [NUM_PLANES-1:0] rd_dirty,
    output logic                  upd_valid,
    input  logic                  upd_ready,
    output logic [LINE_W-1:0]     upd_line,
    output logic [LINE_W-1:0]     upd_count,
    output logic                  clr_valid,
    output logic [PAGE_W-1:0]     clr_first,
    output logic [PAGE_W-1:0]     clr_last,
    output logic [NUM_PLANES-1:0] clr_planes,
    output logic                  busy,
    output logic                  done
);
    localparam logic [LINE_W-1:0] LINE_MASK = LINE_W'(BAND_LINES - 1);

    scan_state_e       state_q;
    logic [PAGE_W-1:0] page_q;
    logic              open_q;
    logic [LINE_W-1:0] first_line_q;
    logic [LINE_W-1:0] height_q;
    logic              deep_q;
    logic              force_q;
    logic              force_pend_q;
    logic              done_q;

    logic [LINE_W-1:0] line_now;
    logic              at_end;
    logic              stall;
    logic              step;
    logic              band_dirty;
    logic              hit;
    logic              emit_mid;
    logic              emit_end;
    logic              load;
    logic [LINE_W-1:0] load_count;
    logic              scan_init;
    logic              ext_any;
    logic [PAGE_W-1:0] ext_lo;
    logic [PAGE_W-1:0] ext_hi;

    assign line_now  = LINE_W'(page_q) << BAND_LOG2;
    assign at_end    = (line_now >= height_q);
    assign step      = (state_q == ST_SCAN) && !stall;
    assign scan_init = (state_q == ST_IDLE) && start;

    assign hit        = step && !at_end && band_dirty;
    assign emit_mid   = step && !at_end && !band_dirty && open_q;
    assign emit_end   = step && at_end && open_q;
    assign load       = emit_mid || emit_end;
    assign load_count = emit_end ? (height_q - first_line_q) : (line_now - first_line_q);

    dbs_dirty_qual u_qual (
        .deep      (deep_q),
        .force_all (force_q),
        .bits      (rd_dirty),
        .dirty     (band_dirty)
    );

    dbs_extent #(.PAGE_W(PAGE_W)) u_extent (
        .clk  (clk),
        .rst  (rst),
        .init (scan_init),
        .hit  (hit),
        .page (page_q),
        .any  (ext_any),
        .lo   (ext_lo),
        .hi   (ext_hi)
    );

    dbs_rect_out #(.LINE_W(LINE_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .line_in   (first_line_q),
        .count_in  (load_count),
        .ready     (upd_ready),
        .valid     (upd_valid),
        .line_out  (upd_line),
        .count_out (upd_count),
        .stall     (stall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            page_q       <= '0;
            open_q       <= 1'b0;
            first_line_q <= '0;
            height_q     <= '0;
            deep_q       <= 1'b0;
            force_q      <= 1'b0;
            force_pend_q <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (scan_init)       force_pend_q <= invalidate;
            else if (invalidate) force_pend_q <= 1'b1;

            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_SCAN;
                        page_q   <= '0;
                        open_q   <= 1'b0;
                        deep_q   <= deep_mode;
                        force_q  <= force_pend_q;
                        height_q <= (frame_height > LINE_W'(MAX_LINES)) ?
                                    LINE_W'(MAX_LINES) : frame_height;
                    end
                end
                ST_SCAN: begin
                    if (step) begin
                        if (at_end) begin
                            open_q  <= 1'b0;
                            state_q <= ST_CLEAR;
                        end else begin
                            page_q <= page_q + 1'b1;
                            if (band_dirty && !open_q) begin
                                open_q       <= 1'b1;
                                first_line_q <= line_now;
                            end else if (!band_dirty) begin
                                open_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_CLEAR: begin
                    state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!upd_valid) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                        force_q <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_page    = page_q;
    assign clr_valid  = (state_q == ST_CLEAR) && ext_any;
    assign clr_first  = ext_lo;
    assign clr_last   = ext_hi;
    assign clr_planes = plane_mask(deep_q);
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;

    AST_CMD_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (upd_count != '0)); // R3
    AST_CMD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (({1'b0, upd_line} + {1'b0, upd_count}) <= {1'b0, height_q})); // R4
    AST_CMD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> ((upd_line & LINE_MASK) == '0)); // R2
    AST_CLR_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> (clr_last < PAGE_W'(NPAGES))); // R7
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> !clr_valid); // R7
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        done |-> (!upd_valid && !busy)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
endmodule

// File: tb/sim_dirty_band_scanner.sv
module sim_dirty_band_scanner;
    localparam int MAXL = 768;
    localparam int NP   = 192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       deep_mode = 1'b0;
    logic       invalidate = 1'b0;
    logic [9:0] frame_height = '0;
    logic [7:0] rd_page;
    logic [2:0] rd_dirty;
    logic       upd_valid;
    logic       upd_ready = 1'b0;
    logic [9:0] upd_line;
    logic [9:0] upd_count;
    logic       clr_valid;
    logic [7:0] clr_first;
    logic [7:0] clr_last;
    logic [2:0] clr_planes;
    logic       busy;
    logic       done;

    always #4 clk = ~clk;

    logic [2:0] bm [NP];
    assign rd_dirty = (rd_page < 8'(NP)) ? bm[rd_page] : 3'b000;

    dirty_band_scanner u0 (
        .clk(clk), .rst(rst), .start(start), .deep_mode(deep_mode),
        .invalidate(invalidate), .frame_height(frame_height),
        .rd_page(rd_page), .rd_dirty(rd_dirty),
        .upd_valid(upd_valid), .upd_ready(upd_ready),
        .upd_line(upd_line), .upd_count(upd_count),
        .clr_valid(clr_valid), .clr_first(clr_first), .clr_last(clr_last),
        .clr_planes(clr_planes), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int got_n, got_y[256], got_h[256];
    int clr_n, clr_lo, clr_hi, clr_m;
    int done_n;
    int exp_n, exp_y[256], exp_h[256];
    bit exp_any;
    int exp_lo, exp_hi;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Expected rectangles and clear range, derived from R2..R8.
    task automatic build_expected(input int h, input bit deep, input bit inv);
        bit open = 0;
        int st = 0;
        exp_n = 0; exp_any = 0; exp_lo = 0; exp_hi = 0;
        for (int p = 0; p * 4 < h; p++) begin
            bit d;
            d = inv || bm[p][0] || (deep && (bm[p][1] || bm[p][2]));
            if (d) begin
                if (!open) begin open = 1; st = p * 4; end
                if (!exp_any) exp_lo = p;
                exp_any = 1;
                exp_hi = p;
            end else if (open) begin
                exp_y[exp_n] = st; exp_h[exp_n] = p * 4 - st; exp_n++;
                open = 0;
            end
        end
        if (open) begin
            exp_y[exp_n] = st; exp_h[exp_n] = h - st; exp_n++;
        end
    endtask

    task automatic run_scan(input int h, input bit deep, input int ready_pct, input int poke);
        int cyc = 0;
        @(negedge clk);
        frame_height = 10'(h); deep_mode = deep; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_n = 0; clr_n = 0; done_n = 0;
        while (done_n == 0 && cyc < 5000) begin
            start = (cyc == poke);
            upd_ready = (int'($urandom % 100) < ready_pct);
            if (upd_valid && upd_ready && got_n < 256) begin
                got_y[got_n] = int'(upd_line); got_h[got_n] = int'(upd_count); got_n++;
            end
            if (clr_valid) begin
                clr_n++;
                clr_lo = int'(clr_first); clr_hi = int'(clr_last); clr_m = int'(clr_planes);
                for (int p = int'(clr_first); p <= int'(clr_last) && p < NP; p++)
                    bm[p] = bm[p] & ~clr_planes;
            end
            if (done) done_n++;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done_n == 1, "R10 done seen", done_n, 1);
    endtask

    task automatic compare(input bit deep);
        chk(got_n == exp_n, "R3 command count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_y[i] == exp_y[i], "R2 rect first line", got_y[i], exp_y[i]);
            chk(got_h[i] == exp_h[i], "R4 rect line count", got_h[i], exp_h[i]);
        end
        chk(clr_n == (exp_any ? 1 : 0), "R7 clear pulses", clr_n, exp_any ? 1 : 0);
        if (exp_any && clr_n == 1) begin
            chk(clr_lo == exp_lo, "R7 clear first", clr_lo, exp_lo);
            chk(clr_hi == exp_hi, "R7 clear last", clr_hi, exp_hi);
            chk(clr_m == (deep ? 7 : 1), "R7 clear planes", clr_m, deep ? 7 : 1);
        end
    endtask

    task automatic clear_map();
        for (int p = 0; p < NP; p++) bm[p] = 3'b000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired: actual 0 expected 1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        clear_map();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(upd_valid == 1'b0, "R1 upd_valid", int'(upd_valid), 0);
        chk(clr_valid == 1'b0, "R1 clr_valid", int'(clr_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);

        // R2 R3 R4 R5: palette mode; plane 1 at page 20 must be ignored.
        bm[2][0] = 1; bm[3][0] = 1; bm[4][0] = 1; bm[10][0] = 1; bm[191][0] = 1;
        bm[20][1] = 1;
        build_expected(768, 0, 0);
        chk(exp_n == 3 && exp_y[0] == 8 && exp_h[0] == 12, "R3 directed model", exp_h[0], 12);
        run_scan(768, 0, 100, -1);
        compare(0);

        // R5 R7: rescan finds nothing; plane 1 stays set.
        build_expected(768, 0, 0);
        run_scan(768, 0, 60, -1);
        compare(0);
        chk(bm[20][1] == 1'b1, "R5 plane1 untouched", int'(bm[20][1]), 1);

        // R6 R4: deep mode, height not a multiple of four.
        bm[190][2] = 1;
        build_expected(762, 1, 0);
        run_scan(762, 1, 50, -1);
        compare(1);
        chk(got_n == 2 && got_y[1] == 760 && got_h[1] == 2, "R4 clipped tail", got_h[1], 2);

        // R8: invalidate forces whole frame.
        clear_map();
        @(negedge clk); invalidate = 1'b1;
        @(negedge clk); invalidate = 1'b0;
        build_expected(100, 0, 1);
        run_scan(100, 0, 70, -1);
        compare(0);
        chk(got_n == 1 && got_y[0] == 0 && got_h[0] == 100, "R8 full rect", got_h[0], 100);
        chk(clr_hi == 24, "R8 clear last page", clr_hi, 24);
        // R8 consumed
        build_expected(100, 0, 0);
        run_scan(100, 0, 100, -1);
        compare(0);
        chk(got_n == 0, "R8 flag consumed", got_n, 0);

        // R10: start while busy is ignored.
        bm[5][0] = 1;
        build_expected(200, 0, 0);
        run_scan(200, 0, 100, 7);
        compare(0);
        for (int k = 0; k < 3; k++) begin
            chk(busy == 1'b0 && done == 1'b0, "R10 no second scan", int'(busy), 0);
            @(negedge clk);
        end

        // R9 and all: random bitmaps, modes, heights and back-pressure.
        for (int it = 0; it < 24; it++) begin
            int dens, h, rp;
            bit dp;
            dens = 5 + int'($urandom % 60);
            for (int p = 0; p < NP; p++)
                for (int b = 0; b < 3; b++)
                    bm[p][b] = (int'($urandom % 100) < dens);
            h  = 1 + int'($urandom % MAXL);
            dp = 1'($urandom % 2);
            rp = 30 + int'($urandom % 71);
            build_expected(h, dp, 0);
            run_scan(h, dp, rp, -1);
            compare(dp); // R9 commands intact under back-pressure
        end

        finish_run();
    end
endmodule